// File: doc/BRIEF.md
# Iterative ChaCha Double-Round Permutation Core

This block applies the 20-round ChaCha permutation to a 16-word state of 32-bit words. This is the permutation that HChaCha20 key derivation uses, with no feed-forward addition at the end. The caller places the complete state on a 512-bit parallel port and pulses a start input. The block then walks ten double rounds and finishes by pulsing done. From that cycle until the next accepted start, the permuted state stays on the parallel output.

The quarterrounds are not unrolled. One add/xor/rotate datapath is shared by every operation. A step decoder tells that datapath which word receives the sum, which word supplies the addend, which word is mixed, and by how much the mixed word is rotated. The decoder takes its answers from a 32-position schedule. Each cycle performs one step, so the working state on the output moves forward one step per clock while the block is busy.

Top module: `chacha_perm_core`

## Requirements
- R1: While reset is active and in the first cycle after it ends, busy_o and done_o are low and state_o is all zeros.
- R2: A start_i pulse is accepted on a rising edge where busy_o is low, including the cycle in which done_o is high. After that edge busy_o is high and state_o equals the loaded state_i. Word xi sits in bits [32i+31:32i].
- R3: After completion, state_o equals the 20-round ChaCha permutation of the loaded state. For the HChaCha20 test input (constants, key bytes 00..1f, nonce 000000090000004a0000000031415927), words x0..x3 are 423b4182 fe7bb227 50420ed3 737d878a and words x12..x15 are d5e4f9a0 53a8748a 13c42ec1 dcecd326.
- R4: done_o goes high on the 320th rising edge after the accepting edge. busy_o goes low on that same edge.
- R5: done_o is high for exactly one cycle.
- R6: A start_i pulse while busy_o is high is ignored. The schedule, the working state and the completion cycle are unchanged.
- R7: While busy_o is low and start_i is low, state_o holds its value whatever is driven on state_i.
- R8: Each busy cycle performs one step, and the result is visible on state_o after that edge. A step changes exactly two words: the target word gains the source word (mod 2^32), then the mix word becomes rotl(mix XOR new target). Within a quarterround (a,b,c,d) the four steps run in this order: (a+=b, mix d), (c+=d, mix b), (a+=b, mix d), (c+=d, mix b).
- R9: The rotate amounts repeat 16, 12, 8, 7 across the steps. Each 32-step double round first covers the columns (i, 4+i, 8+i, 12+i) for i = 0..3. It then covers the diagonals (i, 4+(i+1)%4, 8+(i+2)%4, 12+(i+3)%4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads state_i when idle |
| state_i | input | 512 | Input state, word xi at bits [32i+31:32i] |
| busy_o | output | 1 | High while steps are running |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 512 | Working state; final permuted state once done |

## Verification
Because state_o shows the working state after every step, a wrong lane index, a wrong rotate amount or a swapped add/xor order changes state_o in the very cycle that the bad step runs. A single-bit error then spreads to most of the state within a few steps. The bench therefore compares the whole output against a step-by-step model on every clock. A fault in the round or step counter appears as done_o arriving on the wrong cycle, or as a schedule that drifts from the model one step after the miscount.

// File: rtl/chacha_perm_pkg.sv
package chacha_perm_pkg;

  localparam int WORD_W       = 32;
  localparam int LANES        = 16;
  localparam int LANE_W       = $clog2(LANES);
  localparam int STEPS_PER_DR = 32;
  localparam int STEP_W       = $clog2(STEPS_PER_DR);
  localparam int AMT_W        = $clog2(WORD_W);
  localparam int STATE_W      = WORD_W * LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [AMT_W-1:0]  amt_t;

  // One step of the schedule: tgt += src ; mix = rotl(mix ^ tgt, amt)
  typedef struct packed {
    lane_t tgt;
    lane_t src;
    lane_t mix;
    amt_t  amt;
  } step_op_t;

  // Lane of a quarterround member. Row r of quarterround q in a diagonal pass
  // is shifted r columns to the right (mod 4).
  function automatic lane_t lane_at(input logic diag, input logic [1:0] qr,
                                    input logic [1:0] row);
    logic [1:0] col;
    col = diag ? 2'(qr + row) : qr;
    return {row, col};
  endfunction

  function automatic amt_t rot_amount(input logic [1:0] sub);
    case (sub)
      2'd0:    return amt_t'(16);
      2'd1:    return amt_t'(12);
      2'd2:    return amt_t'(8);
      default: return amt_t'(7);
    endcase
  endfunction

  // Step position: [4] diagonal pass, [3:2] quarterround, [1:0] sub-step.
  function automatic step_op_t decode_step(input logic [STEP_W-1:0] s);
    step_op_t op;
    logic       diag;
    logic [1:0] qr;
    logic [1:0] sub;
    diag = s[4];
    qr   = s[3:2];
    sub  = s[1:0];
    if (!sub[0]) begin
      op.tgt = lane_at(diag, qr, 2'd0);
      op.src = lane_at(diag, qr, 2'd1);
      op.mix = lane_at(diag, qr, 2'd3);
    end else begin
      op.tgt = lane_at(diag, qr, 2'd2);
      op.src = lane_at(diag, qr, 2'd3);
      op.mix = lane_at(diag, qr, 2'd1);
    end
    op.amt = rot_amount(sub);
    return op;
  endfunction

  function automatic word_t rotl(input word_t v, input amt_t n);
    word_t r;
    r = v;
    if (n != '0) r = (v << n) | (v >> (AMT_W'(WORD_W) - {1'b0, n}[AMT_W-1:0]));
    return r;
  endfunction

  function automatic word_t mix_word(input word_t xv, input word_t sum, input amt_t n);
    return rotl(xv ^ sum, n);
  endfunction

endpackage

// File: rtl/chacha_sched.sv
module chacha_sched
  import chacha_perm_pkg::*;
#(
  parameter int DROUNDS = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  output logic     launch_o,
  output logic     step_en_o,
  output logic     last_o,
  output step_op_t op_o,
  output logic     busy_o,
  output logic     done_o
);

  localparam int RND_W = (DROUNDS > 1) ? $clog2(DROUNDS) : 1;
  localparam logic [RND_W-1:0]  RND_LAST  = RND_W'(DROUNDS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS_PER_DR - 1);

  logic              busy_q;
  logic              done_q;
  logic [STEP_W-1:0] step_q;
  logic [RND_W-1:0]  rnd_q;

  assign launch_o  = start_i && !busy_q;
  assign step_en_o = busy_q;
  assign last_o    = busy_q && (step_q == STEP_LAST) && (rnd_q == RND_LAST);
  assign op_o      = decode_step(step_q);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      rnd_q  <= '0;
    end else begin
      done_q <= last_o;
      if (launch_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
        rnd_q  <= '0;
      end else if (busy_q) begin
        step_q <= step_q + STEP_W'(1);
        if (step_q == STEP_LAST) rnd_q <= rnd_q + RND_W'(1);
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  // R4: the round counter never passes the last double round while running
  p_round_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rnd_q <= RND_LAST));

  // R4: completion follows a busy cycle and ends busy
  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (!busy_q && $past(busy_q)));

  // R5: done lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: a start seen while running does not restart the schedule
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !last_o) |=> (busy_q && step_q == STEP_W'($past(step_q) + 1)));

endmodule

// File: rtl/chacha_step_alu.sv
module chacha_step_alu
  import chacha_perm_pkg::*;
(
  input  word_t tgt_val_i,
  input  word_t src_val_i,
  input  word_t mix_val_i,
  input  amt_t  amt_i,
  output word_t sum_o,
  output word_t mixed_o
);

  // Add first, then the xor/rotate consumes the fresh sum (R8 ordering).
  always_comb begin
    sum_o   = tgt_val_i + src_val_i;
    mixed_o = mix_word(mix_val_i, sum_o, amt_i);
  end

  // R9: only the four scheduled rotate amounts ever reach the datapath
  always_comb begin
    if (amt_i != amt_t'(16) && amt_i != amt_t'(12) && amt_i != amt_t'(8) && amt_i != amt_t'(7) && !$isunknown(amt_i))
      p_amount_legal_r9: assert (1'b0);
  end

endmodule

// File: rtl/chacha_state_file.sv
module chacha_state_file
  import chacha_perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_data_i,
  input  logic               step_en_i,
  input  step_op_t           op_i,
  input  word_t              sum_i,
  input  word_t              mixed_i,
  output word_t              tgt_val_o,
  output word_t              src_val_o,
  output word_t              mix_val_o,
  output logic [STATE_W-1:0] flat_o
);

  word_t words_q [LANES];

  assign tgt_val_o = words_q[op_i.tgt];
  assign src_val_o = words_q[op_i.src];
  assign mix_val_o = words_q[op_i.mix];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic wr_sum;
    logic wr_mix;
    assign wr_sum = step_en_i && (op_i.tgt == LANE_W'(g));
    assign wr_mix = step_en_i && (op_i.mix == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        words_q[g] <= '0;
      else if (load_i)   words_q[g] <= load_data_i[g*WORD_W +: WORD_W];
      else if (wr_sum)   words_q[g] <= sum_i;
      else if (wr_mix)   words_q[g] <= mixed_i;
    end

    assign flat_o[g*WORD_W +: WORD_W] = words_q[g];

    // R8: a step leaves every lane it does not name untouched
    p_untouched_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en_i && !load_i && op_i.tgt != LANE_W'(g) && op_i.mix != LANE_W'(g))
      |=> $stable(words_q[g]));
  end

  // R7: no load and no step means the state holds
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_en_i) |=> $stable(flat_o));

  // R8: the summed and mixed lanes of a step are always distinct
  p_distinct_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i |-> (op_i.tgt != op_i.mix && op_i.tgt != op_i.src));

endmodule

// File: rtl/chacha_perm_core.sv
module chacha_perm_core
  import chacha_perm_pkg::*;
#(
  parameter int DROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [511:0] state_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [511:0] state_o
);

  logic     launch_w;
  logic     step_en_w;
  logic     last_w;
  step_op_t op_w;
  word_t    tgt_val_w;
  word_t    src_val_w;
  word_t    mix_val_w;
  word_t    sum_w;
  word_t    mixed_w;

  chacha_sched #(.DROUNDS(DROUNDS)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .launch_o  (launch_w),
    .step_en_o (step_en_w),
    .last_o    (last_w),
    .op_o      (op_w),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  chacha_step_alu u_alu (
    .tgt_val_i (tgt_val_w),
    .src_val_i (src_val_w),
    .mix_val_i (mix_val_w),
    .amt_i     (op_w.amt),
    .sum_o     (sum_w),
    .mixed_o   (mixed_w)
  );

  chacha_state_file u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (launch_w),
    .load_data_i (state_i),
    .step_en_i   (step_en_w),
    .op_i        (op_w),
    .sum_i       (sum_w),
    .mixed_i     (mixed_w),
    .tgt_val_o   (tgt_val_w),
    .src_val_o   (src_val_w),
    .mix_val_o   (mix_val_w),
    .flat_o      (state_o)
  );

  // R2: an accepted start shows the loaded state and busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && state_o == $past(state_i)));

  // R4: the final step is followed by the done pulse
  p_last_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> (done_o && !busy_o));

endmodule

// File: tb/chacha_perm_core_tb.sv
module chacha_perm_core_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [511:0] din;
  logic         busy;
  logic         done;
  logic [511:0] dout;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  chacha_perm_core u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .state_i (din),
    .busy_o  (busy),
    .done_o  (done),
    .state_o (dout)
  );

  // Behavioural model: a list of steps built from the quarterround tuples.
  bit [31:0] m [16];
  int q_tgt[$];
  int q_src[$];
  int q_mix[$];
  int q_amt[$];

  task automatic build_schedule();
    int tup [8][4];
    tup = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
            '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    for (int i = 0; i < 8; i++) begin
      q_tgt.push_back(tup[i][0]); q_src.push_back(tup[i][1]); q_mix.push_back(tup[i][3]); q_amt.push_back(16);
      q_tgt.push_back(tup[i][2]); q_src.push_back(tup[i][3]); q_mix.push_back(tup[i][1]); q_amt.push_back(12);
      q_tgt.push_back(tup[i][0]); q_src.push_back(tup[i][1]); q_mix.push_back(tup[i][3]); q_amt.push_back(8);
      q_tgt.push_back(tup[i][2]); q_src.push_back(tup[i][3]); q_mix.push_back(tup[i][1]); q_amt.push_back(7);
    end
  endtask

  task automatic model_step(input int k);
    int t, s, x, n;
    bit [31:0] v;
    t = q_tgt[k % 32]; s = q_src[k % 32]; x = q_mix[k % 32]; n = q_amt[k % 32];
    m[t] = m[t] + m[s];
    v = m[x] ^ m[t];
    m[x] = (v << n) | (v >> (32 - n));
  endtask

  function automatic logic [511:0] pack_model();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = m[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives start there so the next edge accepts it.
  task automatic do_run(input logic [511:0] st, input int glitch_at);
    start = 1'b1;
    din   = st;
    for (int i = 0; i < 16; i++) m[i] = st[32*i +: 32];
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", 512'(busy), 512'(1));
    chk(done === 1'b0, "R5 done low after start", 512'(done), 512'(0));
    chk(dout === st, "R2 loaded state", dout, st);
    for (int k = 1; k <= 320; k++) begin
      if (k == glitch_at) begin
        start = 1'b1;
        din   = ~st;
      end
      @(negedge clk);
      start = 1'b0;
      model_step(k - 1);
      chk(dout === pack_model(), "R8 R9 per-step state", dout, pack_model());
      chk(done === (k == 320), "R4 done timing", 512'(done), 512'(k == 320));
      chk(busy === (k < 320), "R4 busy timing", 512'(busy), 512'(k < 320));
      if (k > glitch_at && glitch_at > 0)
        chk(dout === pack_model(), "R6 start while busy ignored", dout, pack_model());
    end
  endtask

  logic [511:0] rfc_in;
  logic [511:0] pat;
  logic [511:0] held;
  bit   [31:0]  lcg;

  initial begin
    build_schedule();
    rfc_in = {32'h27594131, 32'h00000000, 32'h4a000000, 32'h09000000,
              32'h1f1e1d1c, 32'h1b1a1918, 32'h17161514, 32'h13121110,
              32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100,
              32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
    rst_n = 1'b0;
    start = 1'b0;
    din   = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 512'(0));
    chk(dout === '0, "R1 reset state", dout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && dout === '0, "R1 after reset", dout, '0);

    // Run 1: HChaCha20 test input
    do_run(rfc_in, 0);
    chk(dout[127:0] === {32'h737d878a, 32'h50420ed3, 32'hfe7bb227, 32'h423b4182},
        "R3 words x0..x3", 512'(dout[127:0]),
        512'({32'h737d878a, 32'h50420ed3, 32'hfe7bb227, 32'h423b4182}));
    chk(dout[511:384] === {32'hdcecd326, 32'h13c42ec1, 32'h53a8748a, 32'hd5e4f9a0},
        "R3 words x12..x15", 512'(dout[511:384]),
        512'({32'hdcecd326, 32'h13c42ec1, 32'h53a8748a, 32'hd5e4f9a0}));
    chk(dout === pack_model(), "R3 full state vs model", dout, pack_model());

    // Idle hold with changing data and no start
    held = dout;
    for (int i = 0; i < 20; i++) begin
      din = {16{32'(i * 32'h9e3779b9)}};
      @(negedge clk);
      chk(done === 1'b0, "R5 done single cycle", 512'(done), 512'(0));
      chk(dout === held, "R7 idle hold", dout, held);
    end

    // Run 2: pseudo-random state, with a start pulse mid-run
    lcg = 32'h1234abcd;
    for (int i = 0; i < 16; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pat[32*i +: 32] = lcg;
    end
    do_run(pat, 150);
    chk(dout === pack_model(), "R3 R6 result after ignored start", dout, pack_model());

    // Run 3: back-to-back start in the done cycle, single-bit input
    pat = '0;
    pat[200] = 1'b1;
    do_run(pat, 0);
    chk(dout === pack_model(), "R2 R3 back-to-back result", dout, pack_model());
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R5 done pulse ends", {busy, done}, 512'(0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule